// File: doc/BRIEF.md
# Parallel Port Controller with Strobed Handshake

This block attaches three 8-bit parallel ports to a simple processor bus. The bus side has a chip select, a two-bit register address, read and write strobes, and an 8-bit data bus. Ports A and B are full byte ports. Port C is a byte of general pins. Each port C pin can serve as a plain data bit, as a single bit that software sets or clears, or as a handshake line for port A or port B.

A write to the control address is decoded in one of two ways, chosen by bit 7 of the written byte. With bit 7 set, the byte is a configuration word. It chooses the direction of each port and of each half of port C, and it selects plain transfer or strobed handshake for ports A and B. With bit 7 clear, the byte is a command that sets or clears one bit of port C.

In handshake mode, the controller and the peripheral pass data under an output-buffer-full / acknowledge protocol or a strobe / input-buffer-full protocol, and an interrupt request is raised for the processor. All pins are sampled on the block clock. Bus strobes are level signals that are sampled once per clock.

Top module: `pport_hs`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A cycle acts only while `cs_n` is low. A write takes effect on each clock edge where `wr_n` is low. `rdata` shows the selected port while `rd_n` is low and is 00h otherwise; address 3 reads as 00h.
- R2: A control write with bit 7 = 1 is a configuration word. Its fields are:
  - bit 4: port A direction (1 = input)
  - bit 3: port C bits 7:4 direction (1 = input)
  - bit 1: port B direction (1 = input)
  - bit 0: port C bits 3:0 direction (1 = input)
  - bit 5 or bit 6: port A handshake
  - bit 2: port B handshake

  Word 80h makes every port a plain output. After reset, every port is a plain input and all latches are 0.
- R3: In plain mode, a written output value is held in a latch and driven on the pins. A read of an input port returns the live pin levels, with no latching.
- R4: The two halves of port C take their directions independently. A read of port C returns the pin levels of input bits and the latch value of output bits.
- R5: A control write with bit 7 = 0 copies bit 0 into the port C latch bit indexed by bits 3:1. All other latch bits and the configuration stay unchanged.
- R6: Any configuration word clears the port A, port B and port C latches and all handshake flags.
- R7: Handshake output uses these port C pins:
  - OBF_n: bit 7 for port A, bit 1 for port B.
  - ACK_n: bit 6 for port A, bit 2 for port B.

  A processor write to the port drives OBF_n low. A low level on ACK_n returns OBF_n high.
- R8: In handshake output, the rising edge of ACK_n sets the port's interrupt flag. The flag appears on bit 3 for port A and bit 0 for port B. The next processor write to that port clears the flag.
- R9: Handshake input uses these port C pins:
  - STB_n: bit 4 for port A, bit 2 for port B.
  - IBF: bit 5 for port A, bit 1 for port B.

  While STB_n is low, the port pins are captured into the input latch and IBF goes high. Reads of the port return the latched value.
- R10: In handshake input, a rising edge of STB_n while IBF is high sets the interrupt flag. A read of the port clears the flag. The clock after the read ends clears IBF.
- R11: The interrupt enables are port C latch bits, changed with bit commands: bit 4 for port A input, bit 6 for port A output, bit 2 for port B. The interrupt pin is the flag AND its enable. Handshake strobe pins are inputs and status pins are driven outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Register select |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values, status included |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
The assertions assume three things about the stimulus:
- a port write and a configuration word never fall in the same cycle;
- a strobe going low never coincides with a processor write to that port;
- an input strobe never rises in the cycle in which that port is being read.

The bench drives every input on the falling clock edge. It holds each bus write for exactly one cycle, and it toggles a handshake strobe only in cycles with no bus activity. Every transfer therefore falls inside those assumptions.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PW   = 8;
  localparam int IDXW = $clog2(PW);

  typedef struct packed {
    logic a_hs;
    logic a_in;
    logic cu_in;
    logic b_hs;
    logic b_in;
    logic cl_in;
  } pport_cfg_t;

  localparam pport_cfg_t CFG_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                       b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pport_cfg_t decode_mode(input logic [6:0] w);
    pport_cfg_t c;
    c.a_hs  = w[6] | w[5];
    c.a_in  = w[4];
    c.cu_in = w[3];
    c.b_hs  = w[2];
    c.b_in  = w[1];
    c.cl_in = w[0];
    return c;
  endfunction

  function automatic logic [PW-1:0] apply_bsr(input logic [PW-1:0] cur,
                                               input logic [IDXW:0] cmd);
    logic [PW-1:0] r;
    r = cur;
    r[cmd[IDXW:1]] = cmd[0];
    return r;
  endfunction
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          pc_wr,
  input  logic [PW-1:0] wdata,
  output pport_cfg_t    cfg,
  output logic [PW-1:0] pc_latch,
  output logic          mode_wr
);
  logic bsr_wr;
  assign mode_wr = ctl_wr & wdata[PW-1];
  assign bsr_wr  = ctl_wr & ~wdata[PW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CFG_RESET;
      pc_latch <= '0;
    end else if (mode_wr) begin
      cfg      <= decode_mode(wdata[6:0]);
      pc_latch <= '0;
    end else if (bsr_wr) begin
      pc_latch <= apply_bsr(pc_latch, wdata[IDXW:0]);
    end else if (pc_wr) begin
      pc_latch <= wdata;
    end
  end

  AST_BSR_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> ($countones(pc_latch ^ $past(pc_latch)) <= 1)); // R5
  AST_BSR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $stable(cfg)); // R5
  AST_MODE_CLEARS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pc_latch == '0)); // R6
endmodule

// File: rtl/pport_chan.sv
module pport_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hs_en,
  input  logic         dir_in,
  input  logic         clr,
  input  logic         wr_port,
  input  logic         rd_port,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  input  logic         strobe_n,
  input  logic         inte,
  output logic [W-1:0] data_q,
  output logic         obf_n,
  output logic         ibf,
  output logic         intr
);
  logic obf_q, ibf_q, intr_q, strobe_q, rd_q;
  logic hs_out, hs_in, ack_low, stb_low, strobe_rise, ack_rise, stb_rise, rd_end;

  assign hs_out      = hs_en & ~dir_in;
  assign hs_in       = hs_en & dir_in;
  assign ack_low     = hs_out & ~strobe_n;
  assign stb_low     = hs_in & ~strobe_n;
  assign strobe_rise = ~strobe_q & strobe_n;
  assign ack_rise    = hs_out & strobe_rise;
  assign stb_rise    = hs_in & strobe_rise;
  assign rd_end      = rd_q & ~rd_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      obf_q    <= 1'b0;
      ibf_q    <= 1'b0;
      intr_q   <= 1'b0;
      strobe_q <= 1'b1;
      rd_q     <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      rd_q     <= rd_port;
      if (clr) begin
        data_q <= '0;
        obf_q  <= 1'b0;
        ibf_q  <= 1'b0;
        intr_q <= 1'b0;
      end else begin
        if (wr_port && !dir_in) data_q <= wdata;
        else if (stb_low)       data_q <= pins;

        if (hs_out && wr_port) obf_q <= 1'b1;
        else if (ack_low)      obf_q <= 1'b0;

        if (stb_low)               ibf_q <= 1'b1;
        else if (hs_in && rd_end)  ibf_q <= 1'b0;

        if ((hs_out && wr_port) || (hs_in && rd_port)) intr_q <= 1'b0;
        else if (ack_rise || (stb_rise && ibf_q))      intr_q <= 1'b1;
      end
    end
  end

  assign obf_n = ~obf_q;
  assign ibf   = ibf_q;
  assign intr  = intr_q & inte;

  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && wr_port && !clr) |=> !obf_n); // R7
  AST_ACK_FREES_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_low && !wr_port && !clr) |=> obf_n); // R7
  AST_IBF_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low && !clr) |=> ibf); // R9
  AST_RD_CLEARS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_in && rd_port && !clr) |=> !intr); // R10
  AST_RDEND_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_in && rd_end && !stb_low && !clr) |=> !ibf); // R10
  AST_WR_CLEARS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && wr_port && !clr) |=> !intr); // R8
endmodule

// File: rtl/pport_hs.sv
module pport_hs
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [1:0]    addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int HALF = PW / 2;

  logic wr_act, rd_act;
  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  pport_cfg_t cfg;
  logic [PW-1:0] pc_latch, a_q, b_q, pc_rd, strobe_mask;
  logic mode_wr;
  logic a_strobe_n, a_inte, a_obf_n, a_ibf, a_intr;
  logic b_obf_n, b_ibf, b_intr;

  assign wr_act = ~cs_n & ~wr_n;
  assign rd_act = ~cs_n & ~rd_n;
  assign wr_a   = wr_act & (addr == 2'd0);
  assign wr_b   = wr_act & (addr == 2'd1);
  assign wr_c   = wr_act & (addr == 2'd2);
  assign wr_ctl = wr_act & (addr == 2'd3);
  assign rd_a   = rd_act & (addr == 2'd0);
  assign rd_b   = rd_act & (addr == 2'd1);

  pport_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .pc_wr(wr_c), .wdata(wdata),
    .cfg(cfg), .pc_latch(pc_latch), .mode_wr(mode_wr)
  );

  assign a_strobe_n = cfg.a_in ? pc_in[4] : pc_in[6];
  assign a_inte     = cfg.a_in ? pc_latch[4] : pc_latch[6];

  pport_chan #(.W(PW)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .hs_en(cfg.a_hs), .dir_in(cfg.a_in), .clr(mode_wr),
    .wr_port(wr_a), .rd_port(rd_a), .wdata(wdata), .pins(pa_in),
    .strobe_n(a_strobe_n), .inte(a_inte),
    .data_q(a_q), .obf_n(a_obf_n), .ibf(a_ibf), .intr(a_intr)
  );

  pport_chan #(.W(PW)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .hs_en(cfg.b_hs), .dir_in(cfg.b_in), .clr(mode_wr),
    .wr_port(wr_b), .rd_port(rd_b), .wdata(wdata), .pins(pb_in),
    .strobe_n(pc_in[2]), .inte(pc_latch[2]),
    .data_q(b_q), .obf_n(b_obf_n), .ibf(b_ibf), .intr(b_intr)
  );

  always_comb begin
    pc_out      = pc_latch;
    pc_oe       = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
    strobe_mask = '0;
    if (cfg.a_hs) begin
      pc_out[3] = a_intr;
      pc_oe[3]  = 1'b1;
      if (cfg.a_in) begin
        pc_out[5] = a_ibf;   pc_oe[5] = 1'b1;
        pc_oe[4]  = 1'b0;    strobe_mask[4] = 1'b1;
      end else begin
        pc_out[7] = a_obf_n; pc_oe[7] = 1'b1;
        pc_oe[6]  = 1'b0;    strobe_mask[6] = 1'b1;
      end
    end
    if (cfg.b_hs) begin
      pc_out[1] = cfg.b_in ? b_ibf : b_obf_n;
      pc_oe[1]  = 1'b1;
      pc_out[0] = b_intr;
      pc_oe[0]  = 1'b1;
      pc_oe[2]  = 1'b0;
      strobe_mask[2] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      if (pc_oe[i])            pc_rd[i] = pc_out[i];
      else if (strobe_mask[i]) pc_rd[i] = pc_latch[i];
      else                     pc_rd[i] = pc_in[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (addr)
        2'd0:    rdata = (cfg.a_in && !cfg.a_hs) ? pa_in : a_q;
        2'd1:    rdata = (cfg.b_in && !cfg.b_hs) ? pb_in : b_q;
        2'd2:    rdata = pc_rd;
        default: rdata = '0;
      endcase
    end
  end

  assign pa_out = a_q;
  assign pa_oe  = ~cfg.a_in;
  assign pb_out = b_q;
  assign pb_oe  = ~cfg.b_in;

  AST_MODE_CLEARS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_out == '0 && pb_out == '0)); // R6
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rdata == '0)); // R1
endmodule

// File: tb/pport_hs_tb.sv
`timescale 1ns/1ps
module pport_hs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
  logic pa_oe, pb_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  pport_hs u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(posedge clk); #1;
    d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse_pc(input int bit_i);
    @(negedge clk); pc_in[bit_i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_pc(input int bit_i);
    pc_in[bit_i] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 reset pa_oe", {7'b0, pa_oe}, 8'h00);
    chk("R2 reset pc_oe", pc_oe, 8'h00);
    chk("R2 reset pa_out", pa_out, 8'h00);
    chk("R1 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_simple_out;
    bus_wr(2'd3, 8'h80);
    chk("R2 80h pb_oe", {7'b0, pb_oe}, 8'h01);
    chk("R2 80h pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h55);
    bus_wr(2'd1, 8'hAA);
    bus_wr(2'd2, 8'h3C);
    chk("R1 port A", pa_out, 8'h55);
    chk("R1 port B", pb_out, 8'hAA);
    chk("R3 port C latch", pc_out, 8'h3C);
    bus_rd(2'd0, rv);
    chk("R3 output readback", rv, 8'h55);
    bus_rd(2'd3, rv);
    chk("R1 control reads zero", rv, 8'h00);
  endtask

  task automatic t_simple_in;
    bus_wr(2'd3, 8'h92);
    chk("R6 B latch cleared", pb_out, 8'h00);
    chk("R6 C latch cleared", pc_out, 8'h00);
    pa_in = 8'hA5;
    bus_rd(2'd0, rv);
    chk("R3 live input", rv, 8'hA5);
    pa_in = 8'h5A;
    bus_rd(2'd0, rv);
    chk("R3 not latched", rv, 8'h5A);
    pb_in = 8'h0F;
    bus_rd(2'd1, rv);
    chk("R1 port B read", rv, 8'h0F);
  endtask

  task automatic t_halves;
    bus_wr(2'd3, 8'h88);
    chk("R4 half directions", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'h36);
    pc_in = 8'hC0;
    bus_rd(2'd2, rv);
    chk("R4 mixed read", rv, 8'hC6);
    pc_in = 8'hFF;
  endtask

  task automatic t_bsr;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h09);
    chk("R5 set bit4", pc_out, 8'h10);
    bus_wr(2'd3, 8'h0F);
    chk("R5 set bit7", pc_out, 8'h90);
    bus_wr(2'd3, 8'h08);
    chk("R5 clear bit4", pc_out, 8'h80);
    chk("R5 cfg kept", {7'b0, pa_oe}, 8'h01);
  endtask

  task automatic t_hs_out_a;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hA0);
    chk("R11 A out pin dirs", pc_oe, 8'hBF);
    chk("R7 idle OBF high", {7'b0, pc_out[7]}, 8'h01);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'hC3);
    chk("R7 data out", pa_out, 8'hC3);
    chk("R7 OBF low", {7'b0, pc_out[7]}, 8'h00);
    pulse_pc(6);
    chk("R7 ACK frees OBF", {7'b0, pc_out[7]}, 8'h01);
    chk("R8 no INTR yet", {7'b0, pc_out[3]}, 8'h00);
    release_pc(6);
    chk("R8 INTR on ACK rise", {7'b0, pc_out[3]}, 8'h01);
    bus_wr(2'd0, 8'h3C);
    chk("R8 write clears INTR", {7'b0, pc_out[3]}, 8'h00);
    chk("R7 OBF low again", {7'b0, pc_out[7]}, 8'h00);
    bus_wr(2'd3, 8'h0C);
    pulse_pc(6);
    release_pc(6);
    chk("R11 INTR masked", {7'b0, pc_out[3]}, 8'h00);
    bus_wr(2'd3, 8'h0D);
    chk("R11 INTR unmasked", {7'b0, pc_out[3]}, 8'h01);
  endtask

  task automatic t_hs_in_a;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hB0);
    chk("R11 A in pin dirs", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h77;
    pulse_pc(4);
    chk("R9 IBF high", {7'b0, pc_out[5]}, 8'h01);
    chk("R10 no INTR yet", {7'b0, pc_out[3]}, 8'h00);
    release_pc(4);
    chk("R10 INTR on STB rise", {7'b0, pc_out[3]}, 8'h01);
    pa_in = 8'h00;
    bus_rd(2'd0, rv);
    chk("R9 latched input", rv, 8'h77);
    chk("R10 read clears INTR", {7'b0, pc_out[3]}, 8'h00);
    chk("R10 IBF held during read", {7'b0, pc_out[5]}, 8'h01);
    @(negedge clk);
    chk("R10 IBF clears after read", {7'b0, pc_out[5]}, 8'h00);
  endtask

  task automatic t_hs_b;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'hE7);
    chk("R7 B data", pb_out, 8'hE7);
    chk("R7 B OBF low", {7'b0, pc_out[1]}, 8'h00);
    pulse_pc(2);
    chk("R7 B ACK frees OBF", {7'b0, pc_out[1]}, 8'h01);
    release_pc(2);
    chk("R8 B INTR", {7'b0, pc_out[0]}, 8'h01);
  endtask

  task automatic t_mode_clear;
    bus_wr(2'd3, 8'h80);
    chk("R6 C cleared", pc_out, 8'h00);
    chk("R6 B cleared", pb_out, 8'h00);
    chk("R6 A cleared", pa_out, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_simple_out();
    t_simple_in();
    t_halves();
    t_bsr();
    t_hs_out_a();
    t_hs_in_a();
    t_hs_b();
    t_mode_clear();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule